// File: doc/BRIEF.md
# Handshake Byte-Transfer Shift Engine

This block passes bytes between a host and a packet store on the controller side. Each byte goes through a single eight-bit data register. The host paces the transfer with two active-low lines: an in-progress strobe and an acknowledge strobe. The block answers on an active-low request line. The host names the direction of the data register on an input. In host-to-block direction, each byte in the data register is appended to an outbound packet buffer. In block-to-host direction, the data register is loaded from an inbound packet buffer, one byte at a time.

Any change of the in-progress/acknowledge pair moves a byte, as long as in-progress stays low; the block needs no bit clock. Each such event schedules a shift interrupt flag. The flag normally rises after a programmable delay in clock cycles. When the host marks all of its port lines as outputs, the flag rises at once. When the host drops in-progress, the block reports the outbound packet and shows on the request line whether inbound bytes are still unread.

Top module: `hs_shift_engine`

## Requirements
- R1: After reset `req_n` is 1, and `sr_irq`, `byte_done`, `out_pkt_valid`, `out_pkt_len` and `sr_rdata` are all 0.
- R2: With `tip_n` low and `dir_host_out`=1, a clock edge on which {`tip_n`,`ack_n`} differs from its value at the previous edge appends `sr_rdata` to the outbound buffer at the next free address, starting at 0. `byte_done` is 1 for the cycle after that edge. While the pair is unchanged, nothing moves.
- R3: When the outbound buffer already holds DEPTH bytes, further moves are dropped. `byte_done` stays 0, the stored bytes keep their values, and the reported length is DEPTH.
- R4: With `tip_n` low and `dir_host_out`=0, a pair change loads the next unread inbound byte into `sr_rdata` and pulses `byte_done`.
- R5: Loading the last inbound byte drives `req_n` to 1. Later pair changes leave `sr_rdata` unchanged and give no `byte_done`.
- R6: On the edge that first sees `tip_n` high after it was low, three things happen. `req_n` goes to 0 if inbound bytes remain unread. `out_pkt_valid` pulses for one cycle with `out_pkt_len` equal to the number of bytes stored, but only if that number is not zero. The outbound index returns to 0.
- R7: With `tip_n` high at this edge and at the previous one, a change of `ack_n` copies the new `ack_n` onto `req_n` and schedules the interrupt.
- R8: A scheduled interrupt sets `sr_irq` exactly DELAY_CYC clock edges after the scheduling edge. A new event restarts the delay.
- R9: When `portb_all_out` is 1, a scheduling event sets `sr_irq` on that same edge.
- R10: `in_commit` sets the inbound length to `in_commit_len` (limited to DEPTH), resets the read index to 0 and schedules the interrupt. The next move then loads inbound byte 0.
- R11: `sr_rd` clears `sr_irq` on the next edge unless the interrupt fires on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tip_n | input | 1 | Host transfer-in-progress, active low |
| ack_n | input | 1 | Host acknowledge, active low |
| req_n | output | 1 | Transfer request to host, active low |
| dir_host_out | input | 1 | 1: host shifts bytes in; 0: block supplies bytes |
| portb_all_out | input | 1 | 1: raise the shift interrupt with no delay |
| sr_wr | input | 1 | Host write strobe for the data register |
| sr_wdata | input | 8 | Host write data |
| sr_rd | input | 1 | Host read strobe; clears the interrupt flag |
| sr_rdata | output | 8 | Data register contents |
| sr_irq | output | 1 | Shift interrupt flag |
| byte_done | output | 1 | One-cycle pulse per byte moved |
| in_wr_en | input | 1 | Inbound buffer write enable |
| in_wr_addr | input | $clog2(DEPTH) | Inbound buffer write address |
| in_wr_data | input | 8 | Inbound buffer write data |
| in_commit | input | 1 | Queue the inbound packet |
| in_commit_len | input | $clog2(DEPTH+1) | Inbound packet length |
| out_pkt_valid | output | 1 | Outbound packet complete pulse |
| out_pkt_len | output | $clog2(DEPTH+1) | Outbound packet length |
| out_rd_addr | input | $clog2(DEPTH) | Outbound buffer read address |
| out_rd_data | output | 8 | Outbound buffer read data |

## Verification
The bench builds the block with DEPTH=4 and DELAY_CYC=5. It sweeps outbound packets from zero to six bytes and inbound packets from one to four bytes. The shallow buffer makes the overflow drop reachable within a few toggles. The short delay lets the bench count every edge up to the interrupt, both for a single event and for an event that restarts a pending delay.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;

    typedef struct packed {
        logic tip_n;
        logic ack_n;
    } hs_pins_t;

    typedef enum logic [1:0] {
        HS_EV_NONE,
        HS_EV_MOVE,
        HS_EV_IDLE_ACK,
        HS_EV_RELEASE
    } hs_event_e;

    localparam logic [7:0] SR_RESET_VAL = 8'h00;

    // Classify the handshake pair against its value at the previous edge.
    function automatic hs_event_e hs_classify(hs_pins_t now_p, hs_pins_t prev_p);
        if (!now_p.tip_n) begin
            return (now_p != prev_p) ? HS_EV_MOVE : HS_EV_NONE;
        end
        if (!prev_p.tip_n) begin
            return HS_EV_RELEASE;
        end
        if (now_p.ack_n != prev_p.ack_n) begin
            return HS_EV_IDLE_ACK;
        end
        return HS_EV_NONE;
    endfunction

endpackage

// File: rtl/hs_irq_delay.sv
module hs_irq_delay #(
    parameter int DELAY_CYC = 30000
) (
    input  logic clk,
    input  logic rst,
    input  logic sched,
    input  logic immediate,
    output logic fire
);
    localparam int CW = $clog2(DELAY_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_comb begin
        fire = (sched && immediate) || (!sched && cnt_q == CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (sched) begin
            cnt_q <= immediate ? '0 : CW'(DELAY_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end
endmodule

// File: rtl/hs_out_buf.sv
module hs_out_buf #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int LW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          clear,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [LW-1:0] count,
    output logic          full
);
    logic [7:0]    mem_q [DEPTH];
    logic [LW-1:0] cnt_q;

    assign count   = cnt_q;
    assign full    = (cnt_q == LW'(DEPTH));
    assign rd_data = mem_q[rd_addr];

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem_q[cnt_q[AW-1:0]] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + LW'(1);
        end
    end
endmodule

// File: rtl/hs_in_buf.sv
module hs_in_buf #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int LW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          commit,
    input  logic [LW-1:0] commit_len,
    input  logic          advance,
    output logic [7:0]    cur_byte,
    output logic          remaining,
    output logic          last
);
    logic [7:0]    mem_q [DEPTH];
    logic [LW-1:0] idx_q;
    logic [LW-1:0] len_q;

    assign remaining = (idx_q < len_q);
    assign last      = ((idx_q + LW'(1)) == len_q);
    assign cur_byte  = mem_q[idx_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            len_q <= '0;
        end else if (commit) begin
            idx_q <= '0;
            len_q <= (commit_len > LW'(DEPTH)) ? LW'(DEPTH) : commit_len;
        end else if (advance) begin
            idx_q <= idx_q + LW'(1);
        end
    end
endmodule

// File: rtl/hs_shift_engine.sv
module hs_shift_engine
    import hs_xfer_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DELAY_CYC = 30000,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tip_n,
    input  logic          ack_n,
    output logic          req_n,
    input  logic          dir_host_out,
    input  logic          portb_all_out,
    input  logic          sr_wr,
    input  logic [7:0]    sr_wdata,
    input  logic          sr_rd,
    output logic [7:0]    sr_rdata,
    output logic          sr_irq,
    output logic          byte_done,
    input  logic          in_wr_en,
    input  logic [AW-1:0] in_wr_addr,
    input  logic [7:0]    in_wr_data,
    input  logic          in_commit,
    input  logic [LW-1:0] in_commit_len,
    output logic          out_pkt_valid,
    output logic [LW-1:0] out_pkt_len,
    input  logic [AW-1:0] out_rd_addr,
    output logic [7:0]    out_rd_data
);
    hs_pins_t  pins_now, pins_q;
    hs_event_e ev;
    logic      move_out, move_in, irq_sched, irq_fire;
    logic      out_full, in_remaining, in_last;
    logic [LW-1:0] out_count;
    logic [7:0]    in_byte, sr_q;

    assign pins_now = '{tip_n: tip_n, ack_n: ack_n};

    always_comb begin
        ev        = hs_classify(pins_now, pins_q);
        move_out  = (ev == HS_EV_MOVE) && dir_host_out && !out_full;
        move_in   = (ev == HS_EV_MOVE) && !dir_host_out && in_remaining && !in_commit;
        irq_sched = move_out || move_in || in_commit ||
                    (ev == HS_EV_IDLE_ACK) || (ev == HS_EV_RELEASE);
    end

    hs_out_buf #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) i_out_buf (
        .clk(clk), .rst(rst),
        .push(move_out), .push_data(sr_q),
        .clear(ev == HS_EV_RELEASE),
        .rd_addr(out_rd_addr), .rd_data(out_rd_data),
        .count(out_count), .full(out_full)
    );

    hs_in_buf #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) i_in_buf (
        .clk(clk), .rst(rst),
        .wr_en(in_wr_en), .wr_addr(in_wr_addr), .wr_data(in_wr_data),
        .commit(in_commit), .commit_len(in_commit_len),
        .advance(move_in),
        .cur_byte(in_byte), .remaining(in_remaining), .last(in_last)
    );

    hs_irq_delay #(.DELAY_CYC(DELAY_CYC)) i_irq_delay (
        .clk(clk), .rst(rst),
        .sched(irq_sched), .immediate(portb_all_out),
        .fire(irq_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q        <= '{tip_n: 1'b1, ack_n: 1'b1};
            req_n         <= 1'b1;
            sr_q          <= SR_RESET_VAL;
            sr_irq        <= 1'b0;
            byte_done     <= 1'b0;
            out_pkt_valid <= 1'b0;
            out_pkt_len   <= '0;
        end else begin
            pins_q        <= pins_now;
            byte_done     <= move_out || move_in;
            out_pkt_valid <= (ev == HS_EV_RELEASE) && (out_count != '0);
            if (ev == HS_EV_RELEASE && out_count != '0) begin
                out_pkt_len <= out_count;
            end
            if (move_in && in_last) begin
                req_n <= 1'b1;
            end else if (ev == HS_EV_IDLE_ACK) begin
                req_n <= ack_n;
            end else if (ev == HS_EV_RELEASE && in_remaining) begin
                req_n <= 1'b0;
            end
            if (move_in) begin
                sr_q <= in_byte;
            end else if (sr_wr) begin
                sr_q <= sr_wdata;
            end
            if (irq_fire) begin
                sr_irq <= 1'b1;
            end else if (sr_rd) begin
                sr_irq <= 1'b0;
            end
        end
    end

    assign sr_rdata = sr_q;
endmodule

// File: rtl/hs_shift_engine_chk.sv
module hs_shift_engine_chk #(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          tip_n,
    input logic          sr_rd,
    input logic          sr_irq,
    input logic          irq_fire,
    input logic          irq_sched,
    input logic          portb_all_out,
    input logic          byte_done,
    input logic          out_pkt_valid,
    input logic [LW-1:0] out_pkt_len
);
    a_r2_move_needs_tip: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> $past(!tip_n));

    a_r3_len_bounded: assert property (@(posedge clk) disable iff (rst)
        out_pkt_len <= LW'(DEPTH));

    a_r6_report_on_release: assert property (@(posedge clk) disable iff (rst)
        out_pkt_valid |-> ($past(tip_n) && out_pkt_len != '0));

    a_r9_immediate_set: assert property (@(posedge clk) disable iff (rst)
        (irq_sched && portb_all_out) |=> sr_irq);

    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
        (sr_rd && !irq_fire) |=> !sr_irq);
endmodule

bind hs_shift_engine hs_shift_engine_chk #(.DEPTH(DEPTH), .LW(LW)) i_chk (
    .clk(clk), .rst(rst), .tip_n(tip_n), .sr_rd(sr_rd), .sr_irq(sr_irq),
    .irq_fire(irq_fire), .irq_sched(irq_sched), .portb_all_out(portb_all_out),
    .byte_done(byte_done), .out_pkt_valid(out_pkt_valid), .out_pkt_len(out_pkt_len)
);

// File: tb/test_hs_shift_engine.sv
module test_hs_shift_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int DELAY = 5;
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tip_n = 1'b1, ack_n = 1'b1, dir_host_out = 1'b0, portb_all_out = 1'b0;
    logic sr_wr = 1'b0, sr_rd = 1'b0, in_wr_en = 1'b0, in_commit = 1'b0;
    logic [7:0] sr_wdata = '0, in_wr_data = '0;
    logic [AW-1:0] in_wr_addr = '0, out_rd_addr = '0;
    logic [LW-1:0] in_commit_len = '0;
    logic req_n, sr_irq, byte_done, out_pkt_valid;
    logic [7:0] sr_rdata, out_rd_data;
    logic [LW-1:0] out_pkt_len;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hs_shift_engine #(.DEPTH(DEPTH), .DELAY_CYC(DELAY)) i_hs_shift_engine (
        .clk(clk), .rst(rst), .tip_n(tip_n), .ack_n(ack_n), .req_n(req_n),
        .dir_host_out(dir_host_out), .portb_all_out(portb_all_out),
        .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_rd(sr_rd), .sr_rdata(sr_rdata),
        .sr_irq(sr_irq), .byte_done(byte_done),
        .in_wr_en(in_wr_en), .in_wr_addr(in_wr_addr), .in_wr_data(in_wr_data),
        .in_commit(in_commit), .in_commit_len(in_commit_len),
        .out_pkt_valid(out_pkt_valid), .out_pkt_len(out_pkt_len),
        .out_rd_addr(out_rd_addr), .out_rd_data(out_rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_sr(input logic [7:0] v);
        sr_wr = 1'b1; sr_wdata = v;
        tick();
        sr_wr = 1'b0;
    endtask

    task automatic clear_irq();
        sr_rd = 1'b1;
        tick();
        sr_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (DELAY + 2) tick();
        clear_irq();
    endtask

    task automatic load_in(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            in_wr_en = 1'b1; in_wr_addr = AW'(i); in_wr_data = 8'(seed + i * 7);
            tick();
        end
        in_wr_en = 1'b0;
    endtask

    task automatic commit(input int n);
        in_commit = 1'b1; in_commit_len = LW'(n);
        tick();
        in_commit = 1'b0;
    endtask

    // Call right after the scheduling edge.
    task automatic expect_delay(input string req);
        check(req, int'(sr_irq), 0);
        for (int j = 1; j < DELAY; j++) begin
            tick();
            check(req, int'(sr_irq), 0);
        end
        tick();
        check(req, int'(sr_irq), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", int'(req_n), 1);
        check("R1", int'(sr_irq), 0);
        check("R1", int'(byte_done), 0);
        check("R1", int'(out_pkt_valid), 0);
        check("R1", int'(out_pkt_len), 0);
        check("R1", int'(sr_rdata), 0);

        // R2 / R3 / R6: outbound sweep 0..DEPTH+2 bytes
        dir_host_out = 1'b1;
        for (int n = 0; n <= DEPTH + 2; n++) begin
            for (int i = 0; i < n; i++) begin
                write_sr(8'(n * 16 + i + 1));
                if (i == 0) tip_n = 1'b0; else ack_n = ~ack_n;
                tick();
                check(i < DEPTH ? "R2" : "R3", int'(byte_done), (i < DEPTH) ? 1 : 0);
                if (i == 0) begin
                    tick();
                    check("R2", int'(byte_done), 0);
                end
            end
            if (n > 0) begin
                tip_n = 1'b1;
                tick();
                check("R6", int'(out_pkt_valid), 1);
                check(n > DEPTH ? "R3" : "R6", int'(out_pkt_len), (n < DEPTH) ? n : DEPTH);
                tick();
                check("R6", int'(out_pkt_valid), 0);
                for (int a = 0; a < ((n < DEPTH) ? n : DEPTH); a++) begin
                    out_rd_addr = AW'(a);
                    #1;
                    check(n > DEPTH ? "R3" : "R2", int'(out_rd_data), (n * 16 + a + 1) % 256);
                end
            end
            settle();
        end

        // R4 / R5: inbound sweep 1..DEPTH bytes
        dir_host_out = 1'b0;
        for (int n = 1; n <= DEPTH; n++) begin
            load_in(n, 16 * n + 3);
            commit(n);
            for (int i = 0; i <= n; i++) begin
                if (i == 0) tip_n = 1'b0; else ack_n = ~ack_n;
                tick();
                if (i < n) begin
                    check("R4", int'(sr_rdata), (16 * n + 3 + i * 7) % 256);
                    check("R4", int'(byte_done), 1);
                    if (i == n - 1) check("R5", int'(req_n), 1);
                end else begin
                    check("R5", int'(byte_done), 0);
                    check("R5", int'(sr_rdata), (16 * n + 3 + (n - 1) * 7) % 256);
                end
            end
            tip_n = 1'b1;
            tick();
            check("R6", int'(req_n), 1);
            check("R6", int'(out_pkt_valid), 0);
            settle();
        end

        // R6: release with unread inbound bytes pulls request low
        load_in(2, 8'h5A);
        commit(2);
        tip_n = 1'b0; tick();
        check("R4", int'(sr_rdata), 8'h5A);
        tip_n = 1'b1; tick();
        check("R6", int'(req_n), 0);
        tip_n = 1'b0; tick();
        check("R4", int'(sr_rdata), (8'h5A + 7) % 256);
        check("R5", int'(req_n), 1);
        tip_n = 1'b1; tick();
        settle();

        // R10: new commit mid-packet restarts the read index
        load_in(3, 8'h11);
        commit(3);
        tip_n = 1'b0; tick();
        check("R10", int'(sr_rdata), 8'h11);
        ack_n = ~ack_n; tick();
        check("R10", int'(sr_rdata), 8'h18);
        load_in(2, 8'h40);
        commit(2);
        ack_n = ~ack_n; tick();
        check("R10", int'(sr_rdata), 8'h40);
        ack_n = ~ack_n; tick();
        check("R10", int'(sr_rdata), 8'h47);
        check("R10", int'(req_n), 1);
        tip_n = 1'b1; tick();
        settle();

        // R10 / R8: commit schedules the delayed interrupt
        in_commit = 1'b1; in_commit_len = LW'(0);
        tick();
        in_commit = 1'b0;
        expect_delay("R10");
        clear_irq();
        check("R11", int'(sr_irq), 0);

        // R7: idle acknowledge toggles drive the request line
        ack_n = 1'b0; tick();
        check("R7", int'(req_n), 0);
        settle();
        ack_n = 1'b1; tick();
        check("R7", int'(req_n), 1);
        expect_delay("R8");
        clear_irq();

        // R8: a second event restarts the pending delay
        ack_n = ~ack_n; tick();
        repeat (2) tick();
        ack_n = ~ack_n; tick();
        expect_delay("R8");
        clear_irq();

        // R9: immediate interrupt when all port lines are outputs
        portb_all_out = 1'b1;
        ack_n = ~ack_n; tick();
        check("R9", int'(sr_irq), 1);
        portb_all_out = 1'b0;
        tick();
        // R11: reading the data register clears the flag
        sr_rd = 1'b1; tick(); sr_rd = 1'b0;
        check("R11", int'(sr_irq), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule